// File: doc/BRIEF.md
# Command Ring Pointer and Watermark Controller

This block keeps the addresses of a command ring buffer held in memory. The ring is bounded by a programmable base address and a programmable top address. A producer signals each command chunk it has written with a one-cycle `push` strobe. A consumer engine asks to fetch the next chunk with `pop_req`. The controller moves a write pointer and a read pointer through the ring by 32 bytes per step and wraps each pointer back to the base when the next step would pass the top. It also keeps a byte count of the distance between the two pointers.

Three sticky flags report conditions that software asks to watch. The overflow flag sets when the write pointer is above a high mark. The underflow flag sets when the read pointer is above a low mark. The breakpoint flag sets when the read pointer reaches a breakpoint address, and the controller then stops granting reads. All state is reached through a 16-bit register bus that is addressed in halfwords. Each 32-bit address is split into a low half and a high half.

The consumer side is a three-state machine:
- IDLE waits for a request. It takes the *grant* transition to FETCH when a read is allowed. It takes the *halt* transition to HALT when the read pointer equals the enabled breakpoint.
- FETCH lasts one cycle, during which `pop_ack` is high. It takes the *retire* transition back to IDLE, and the read pointer advances on that edge.
- HALT blocks all reads. It takes the *release* transition to IDLE once the breakpoint check is disabled or the two addresses no longer match.

Top module: `cmdring_ctrl`

## Requirements
- R1: After reset every address register, the control register and every flag are zero, and the status halfword (word 0) reads 0x000C.
- R2: Register words: 0 is status and read-only, 1 is control, and 2 is clear, which reads 0. Words 0x10+2k and 0x11+2k hold the low and high halves of register k, in this order: base, top, high mark, low mark, count, write pointer, read pointer, breakpoint. Control keeps bits 0, 2, 3, 4 and 5 and reads bit 1 as 0. Unused bits read 0.
- R3: A `push` advances the write pointer by 32 and adds 32 to the count only while control bit 4 (link) is 1. With link at 0, `push` has no effect.
- R4: When a pointer plus 32 is greater than the top address (unsigned), the advance loads the base address instead.
- R5: A `pop_req` seen in IDLE is granted only if control bit 0 is 1, the count is non-zero and no breakpoint halt applies. A grant raises `pop_ack` for exactly the next cycle. At the end of that cycle the read pointer advances and the count drops by 32.
- R6: When a write advance and a read advance happen in the same cycle, the count is unchanged.
- R7: Status bit 0 (overflow) sets the cycle after the write pointer is greater than the high mark while control bit 2 is 1. It is sticky and is cleared by writing 1 to clear bit 0. A set condition in the same cycle as the clear wins.
- R8: Status bit 1 (underflow) sets the cycle after the read pointer is greater than the low mark while control bit 3 is 1. It is sticky, is cleared by writing 1 to clear bit 1, and a set condition wins over the clear.
- R9: With control bit 5 set, a read pointer equal to the breakpoint address in IDLE moves to HALT and sets status bit 4. No read is granted while halted. Writing control with bit 1 at 1 clears status bit 4.
- R10: Status bit 2 reads 1 when the count is zero or control bit 0 is 0. Status bit 3 reads 1 except during a FETCH cycle.
- R11: A bus write to either half of a pointer or of the count takes precedence over an advance of that register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_word | input | 5 | Halfword register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational from `reg_word`) |
| push | input | 1 | Producer write-advance strobe |
| pop_req | input | 1 | Consumer read request |
| pop_ack | output | 1 | Read granted; high during the FETCH cycle |
| wr_addr | output | 32 | Current write pointer |
| rd_addr | output | 32 | Current read pointer |

## Verification
The hardest situation to reach is the breakpoint halt. It needs the read pointer to land exactly on the breakpoint while data is still pending. The stimulus sets the breakpoint one step ahead of the read pointer, pushes extra chunks and then pops once. The next request must be refused, and the status must show the hit. A clear through control bit 1 must release the halt. Watermark boundaries are driven to the exact equal address and then one step beyond. Simultaneous push and pop are forced by raising `push` during the FETCH cycle. A seeded random mix of pushes, pops and combined operations over a small ring exercises wrap-around and the count-zero refusal against a bench-side model.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;
    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_FETCH = 2'd1,
        RS_HALT  = 2'd2
    } rd_state_t;

    localparam int NREG    = 8;
    localparam int IX_BASE = 0;
    localparam int IX_TOP  = 1;
    localparam int IX_HI   = 2;
    localparam int IX_LO   = 3;
    localparam int IX_CNT  = 4;
    localparam int IX_WR   = 5;
    localparam int IX_RD   = 6;
    localparam int IX_BP   = 7;
endpackage

// File: rtl/cmdring_half_reg.sv
module cmdring_half_reg #(
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_lo,
    input  logic          we_hi,
    input  logic [HW-1:0] wd,
    output logic [2*HW-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            if (we_lo) q[HW-1:0]    <= wd;
            if (we_hi) q[2*HW-1:HW] <= wd;
        end
    end
endmodule

// File: rtl/cmdring_ptr.sv
module cmdring_ptr #(
    parameter int HW   = 16,
    parameter int STEP = 32,
    localparam int AW  = 2*HW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          we_lo,
    input  logic          we_hi,
    input  logic [HW-1:0] wd,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] top,
    output logic [AW-1:0] q
);
    logic [AW:0]   sum;
    logic          past_top;
    logic [AW-1:0] nxt;

    always_comb begin
        sum      = {1'b0, q} + (AW+1)'(STEP);
        past_top = sum > {1'b0, top};
        nxt      = past_top ? base : sum[AW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we_lo || we_hi) begin
            if (we_lo) q[HW-1:0]    <= wd;
            if (we_hi) q[AW-1:HW]   <= wd;
        end else if (adv) begin
            q <= nxt;
        end
    end

    // R4: an advance that would pass the top lands on the base
    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !we_lo && !we_hi && ({1'b0, q} + (AW+1)'(STEP) > {1'b0, top}))
        |=> q == $past(base));

    // R11: a bus write beats an advance
    p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (we_lo && !we_hi) |=> q[HW-1:0] == $past(wd));
endmodule

// File: rtl/cmdring_rd_fsm.sv
module cmdring_rd_fsm
    import cmdring_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pop_req,
    input  logic rd_en,
    input  logic cnt_zero,
    input  logic bp_hit,
    output logic rd_adv,
    output logic bp_set,
    output logic in_flight
);
    rd_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE: begin
                if (bp_hit)                            state_d = RS_HALT;
                else if (pop_req && rd_en && !cnt_zero) state_d = RS_FETCH;
            end
            RS_FETCH: state_d = RS_IDLE;
            RS_HALT:  if (!bp_hit) state_d = RS_IDLE;
            default:  state_d = RS_IDLE;
        endcase
    end

    always_comb begin
        rd_adv    = (state_q == RS_FETCH);
        in_flight = (state_q == RS_FETCH);
        bp_set    = (state_q == RS_IDLE) && bp_hit;
    end

    // R5: a grant lasts exactly one cycle
    p_one_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_adv |=> !rd_adv);

    // R5: no grant without an allowed request
    p_grant_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_adv && !(pop_req && rd_en && !cnt_zero)) |=> !rd_adv);
endmodule

// File: rtl/cmdring_ctrl.sv
module cmdring_ctrl
    import cmdring_pkg::*;
#(
    parameter int HW   = 16,
    parameter int STEP = 32,
    localparam int AW  = 2*HW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [4:0]    reg_word,
    input  logic [HW-1:0] reg_wdata,
    output logic [HW-1:0] reg_rdata,
    input  logic          push,
    input  logic          pop_req,
    output logic          pop_ack,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr
);
    logic [NREG-1:0] wlo, whi;
    logic            ctrl_wr, clr_wr;
    logic [5:0]      ctl_q;
    logic [AW-1:0]   rb [NREG];
    logic [AW-1:0]   cnt_q, wr_q, rd_q;
    logic            w_adv, r_adv, bp_set, in_flight, bp_hit;
    logic            ovf_q, unf_q, bp_q, ovf_set, unf_set;
    logic [HW-1:0]   status;

    // bus decode
    always_comb begin
        wlo = '0;
        whi = '0;
        if (reg_we && reg_word[4]) begin
            if (reg_word[0]) whi[reg_word[3:1]] = 1'b1;
            else             wlo[reg_word[3:1]] = 1'b1;
        end
        ctrl_wr = reg_we && (reg_word == 5'd1);
        clr_wr  = reg_we && (reg_word == 5'd2);
    end

    assign w_adv = push && ctl_q[4];

    // address registers: plain storage or live pointers
    for (genvar i = 0; i < NREG; i++) begin : g_areg
        if (i == IX_WR) begin : g_wr
            cmdring_ptr #(.HW(HW), .STEP(STEP)) u_ptr (
                .clk(clk), .rst_n(rst_n), .adv(w_adv),
                .we_lo(wlo[i]), .we_hi(whi[i]), .wd(reg_wdata),
                .base(rb[IX_BASE]), .top(rb[IX_TOP]), .q(wr_q));
            assign rb[i] = wr_q;
        end else if (i == IX_RD) begin : g_rd
            cmdring_ptr #(.HW(HW), .STEP(STEP)) u_ptr (
                .clk(clk), .rst_n(rst_n), .adv(r_adv),
                .we_lo(wlo[i]), .we_hi(whi[i]), .wd(reg_wdata),
                .base(rb[IX_BASE]), .top(rb[IX_TOP]), .q(rd_q));
            assign rb[i] = rd_q;
        end else if (i == IX_CNT) begin : g_cnt
            assign rb[i] = cnt_q;
        end else begin : g_plain
            cmdring_half_reg #(.HW(HW)) u_reg (
                .clk(clk), .rst_n(rst_n), .we_lo(wlo[i]), .we_hi(whi[i]),
                .wd(reg_wdata), .q(rb[i]));
        end
    end

    // distance count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wlo[IX_CNT] || whi[IX_CNT]) begin
            if (wlo[IX_CNT]) cnt_q[HW-1:0]  <= reg_wdata;
            if (whi[IX_CNT]) cnt_q[AW-1:HW] <= reg_wdata;
        end else begin
            case ({w_adv, r_adv})
                2'b10:   cnt_q <= cnt_q + AW'(STEP);
                2'b01:   cnt_q <= cnt_q - AW'(STEP);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign bp_hit = ctl_q[5] && (rd_q == rb[IX_BP]);

    cmdring_rd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .pop_req(pop_req), .rd_en(ctl_q[0]),
        .cnt_zero(cnt_q == '0), .bp_hit(bp_hit),
        .rd_adv(r_adv), .bp_set(bp_set), .in_flight(in_flight));

    // control and sticky flags
    assign ovf_set = ctl_q[2] && (wr_q > rb[IX_HI]);
    assign unf_set = ctl_q[3] && (rd_q > rb[IX_LO]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
            bp_q  <= 1'b0;
        end else begin
            if (ctrl_wr) ctl_q <= {reg_wdata[5:2], 1'b0, reg_wdata[0]};
            ovf_q <= ovf_set || (ovf_q && !(clr_wr && reg_wdata[0]));
            unf_q <= unf_set || (unf_q && !(clr_wr && reg_wdata[1]));
            bp_q  <= bp_set  || (bp_q  && !(ctrl_wr && reg_wdata[1]));
        end
    end

    assign status = {{(HW-5){1'b0}}, bp_q, !in_flight,
                     (cnt_q == '0) || !ctl_q[0], unf_q, ovf_q};

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_word[4]) begin
            reg_rdata = reg_word[0] ? rb[reg_word[3:1]][AW-1:HW]
                                    : rb[reg_word[3:1]][HW-1:0];
        end else begin
            case (reg_word[3:0])
                4'd0:    reg_rdata = status;
                4'd1:    reg_rdata = {{(HW-6){1'b0}}, ctl_q};
                default: reg_rdata = '0;
            endcase
        end
    end

    assign pop_ack = in_flight;
    assign wr_addr = wr_q;
    assign rd_addr = rd_q;

    // R6: simultaneous advances keep the count
    p_cnt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (w_adv && r_adv && !wlo[IX_CNT] && !whi[IX_CNT]) |=> cnt_q == $past(cnt_q));

    // R3: with link off a push moves nothing
    p_link_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !ctl_q[4] && !wlo[IX_WR] && !whi[IX_WR]) |=> $stable(wr_q));

    // R7: overflow is sticky until cleared
    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !(clr_wr && reg_wdata[0])) |=> ovf_q);

    // R8: underflow is sticky until cleared
    p_unf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_q && !(clr_wr && reg_wdata[1])) |=> unf_q);

    // R9: a matching enabled breakpoint blocks the next grant
    p_bp_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_hit && !pop_ack) |=> !pop_ack);
endmodule

// File: tb/cmdring_ctrl_bench.sv
`timescale 1ns/1ps
module cmdring_ctrl_bench;
    localparam logic [31:0] BASE = 32'h0000_1000;
    localparam logic [31:0] TOP  = 32'h0000_10E0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_word = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        push = 1'b0;
    logic        pop_req = 1'b0;
    logic        pop_ack;
    logic [31:0] wr_addr, rd_addr;

    int tests = 0;
    int fails = 0;
    logic [31:0] mw, mr, mc;

    always #2.5 clk = ~clk;

    cmdring_ctrl u_cmdring_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_word(reg_word),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .push(push),
        .pop_req(pop_req), .pop_ack(pop_ack), .wr_addr(wr_addr), .rd_addr(rd_addr));

    function automatic logic [31:0] step(input logic [31:0] p);
        logic [32:0] s;
        s = {1'b0, p} + 33'd32;
        return (s > {1'b0, TOP}) ? BASE : s[31:0];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr16(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_word = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wr32(input logic [4:0] a, input logic [31:0] d);
        wr16(a, d[15:0]);
        wr16(a | 5'd1, d[31:16]);
    endtask

    task automatic rd16(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_word = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd32(input logic [4:0] a, output logic [31:0] d);
        logic [15:0] lo, hi;
        rd16(a, lo);
        rd16(a | 5'd1, hi);
        d = {hi, lo};
    endtask

    task automatic do_push();
        @(negedge clk); push = 1'b1;
        @(negedge clk); push = 1'b0;
    endtask

    task automatic do_pop(output logic ack, output logic [15:0] st);
        @(negedge clk); pop_req = 1'b1;
        @(negedge clk); pop_req = 1'b0; reg_word = 5'd0;
        #1 ack = pop_ack; st = reg_rdata;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R5 watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] d16, st;
        logic [31:0] d32;
        logic        ack;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd16(5'd0, d16);  check("R1 status", {16'h0, d16}, 32'h000C);
        rd32(5'h1A, d32); check("R1 wr_ptr", d32, 32'h0);
        rd32(5'h18, d32); check("R1 count", d32, 32'h0);
        rd16(5'd1, d16);  check("R1 control", {16'h0, d16}, 32'h0);

        // control readback and clear register
        wr16(5'd1, 16'hFFFF);
        rd16(5'd1, d16);  check("R2 control readback", {16'h0, d16}, 32'h003D);
        rd16(5'd2, d16);  check("R2 clear reads zero", {16'h0, d16}, 32'h0);
        wr16(5'd1, 16'h0000);
        wr32(5'h10, BASE); wr32(5'h12, TOP);
        wr32(5'h1A, BASE); wr32(5'h1C, BASE);
        rd32(5'h12, d32); check("R2 top halves", d32, TOP);

        // link off: push ignored
        do_push();
        check("R3 link off wr_addr", wr_addr, BASE);
        rd32(5'h18, d32); check("R3 link off count", d32, 32'h0);

        // overflow
        wr32(5'h14, 32'h0000_1040);
        wr16(5'd1, 16'h0015);
        do_push(); do_push();
        rd16(5'd0, d16); check("R7 equal mark no overflow", {31'h0, d16[0]}, 32'h0);
        do_push();
        check("R3 wr_addr", wr_addr, 32'h0000_1060);
        rd16(5'd0, d16); check("R7 overflow set", {31'h0, d16[0]}, 32'h1);
        wr16(5'd2, 16'h0001);
        rd16(5'd0, d16); check("R7 set wins over clear", {31'h0, d16[0]}, 32'h1);
        wr16(5'd1, 16'h0011);
        wr16(5'd2, 16'h0001);
        rd16(5'd0, d16); check("R7 overflow cleared", {31'h0, d16[0]}, 32'h0);
        rd32(5'h18, d32); check("R3 count", d32, 32'd96);

        // underflow
        wr32(5'h16, 32'h0000_1020);
        wr16(5'd1, 16'h0019);
        do_pop(ack, st);
        check("R5 pop granted", {31'h0, ack}, 32'h1);
        check("R10 busy during fetch", {31'h0, st[3]}, 32'h0);
        rd16(5'd0, d16); check("R8 equal mark no underflow", {31'h0, d16[1]}, 32'h0);
        check("R10 idle after fetch", {31'h0, d16[3]}, 32'h1);
        do_pop(ack, st);
        rd16(5'd0, d16); check("R8 underflow set", {31'h0, d16[1]}, 32'h1);
        wr16(5'd1, 16'h0011);
        wr16(5'd2, 16'h0002);
        rd16(5'd0, d16); check("R8 underflow cleared", {31'h0, d16[1]}, 32'h0);
        rd32(5'h18, d32); check("R5 count after pops", d32, 32'd32);
        check("R5 rd_addr", rd_addr, 32'h0000_1040);

        // breakpoint
        wr32(5'h1E, 32'h0000_1060);
        wr16(5'd1, 16'h0031);
        do_push();
        do_pop(ack, st); check("R9 pop before breakpoint", {31'h0, ack}, 32'h1);
        do_pop(ack, st); check("R9 pop refused at breakpoint", {31'h0, ack}, 32'h0);
        rd16(5'd0, d16); check("R9 breakpoint flag", {31'h0, d16[4]}, 32'h1);
        rd32(5'h18, d32); check("R9 count held", d32, 32'd32);
        wr16(5'd1, 16'h0013);
        rd16(5'd1, d16); check("R2 bit1 reads zero", {16'h0, d16}, 32'h0011);
        rd16(5'd0, d16); check("R9 breakpoint cleared", {31'h0, d16[4]}, 32'h0);
        do_pop(ack, st); check("R9 pop after release", {31'h0, ack}, 32'h1);
        check("R5 rd_addr after release", rd_addr, 32'h0000_1080);
        do_pop(ack, st); check("R5 refused at count zero", {31'h0, ack}, 32'h0);
        check("R10 idle reading at count zero", {31'h0, st[2]}, 32'h1);

        // bus write beats advance
        @(negedge clk);
        reg_we = 1'b1; reg_word = 5'h1A; reg_wdata = 16'h10C0; push = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; push = 1'b0;
        check("R11 write wins over push", wr_addr, 32'h0000_10C0);
        rd32(5'h18, d32); check("R11 count", d32, 32'd32);
        wr16(5'd1, 16'h0010);
        rd16(5'd0, d16); check("R10 idle reading when disabled", {31'h0, d16[2]}, 32'h1);
        wr16(5'd1, 16'h0011);
        mw = 32'h0000_10C0; mr = 32'h0000_1080; mc = 32'd32;

        // random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            logic exp_ack;
            op = int'($urandom % 3);
            exp_ack = (mc != 0);
            if (op == 0) begin
                do_push();
                mw = step(mw); mc = mc + 32;
                check("R4 wr_addr", wr_addr, mw);
            end else if (op == 1) begin
                do_pop(ack, st);
                check("R5 random grant", {31'h0, ack}, {31'h0, exp_ack});
                if (exp_ack) begin mr = step(mr); mc = mc - 32; end
                check("R4 rd_addr", rd_addr, mr);
            end else begin
                @(negedge clk); pop_req = 1'b1;
                @(negedge clk); pop_req = 1'b0; push = 1'b1; ack = pop_ack;
                @(negedge clk); push = 1'b0;
                check("R6 combined grant", {31'h0, ack}, {31'h0, exp_ack});
                mw = step(mw);
                if (exp_ack) mr = step(mr);
                else mc = mc + 32;
                check("R6 rd_addr", rd_addr, mr);
            end
            rd32(5'h18, d32); check("R6 count", d32, mc);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule